// File: doc/BRIEF.md
# Interrupt Vector Priority Decoder

This block sits beside a CPU core and turns a set of pending exception and interrupt request lines into one 16-bit vector address. It has six fixed sources: system reset, clock-monitor reset, watchdog reset, illegal-opcode trap, software interrupt and the non-maskable-by-I external interrupt. It also has `N_MASK` I-maskable sources. All of them are ranked by a fixed order. The block does not pick a winner when a request first rises. It picks one when the CPU strobes `vec_req`, so a more urgent request that arrives late in the entry sequence still wins.

The block tracks each interrupt sequence. While a sequence is open, it keeps the vector of the most recent valid winner. If every request has gone away by the time the CPU asks, the block returns that kept vector. If nothing was pending at all, it returns the software-interrupt vector. A small register can promote one maskable source to the head of the maskable group.

Top module: `irq_vec_decoder`

## Requirements
- R1: The fixed sources rank from highest to lowest as follows. Bit 0 is `rst_src` with vector 0xFFFE. Next come `clkmon_src` at 0xFFFC, `wdog_src` at 0xFFFA, `trap_src` at 0xFFF8, `swi_src` at 0xFFF6, and last `xirq_src` at 0xFFF4.
- R2: Maskable source k (`irq_src[k]`) has vector 0xFFF2 − 2·k. Lower k has higher priority. Every maskable source ranks below all fixed sources.
- R3: When `i_mask` is 1, no maskable source is valid. When `x_mask` is 1, `xirq_src` is not valid. The other fixed sources are never masked.
- R4: The promotion register resets to 0xF2 and is loaded from `prom_wdata` when `prom_we` is high. If it holds the low byte of a source k's vector and that source is valid, source k beats every other maskable source. It does not beat the fixed sources. A value that matches no source leaves the default order unchanged.
- R5: `vec_valid` is high for exactly the one cycle after a cycle with `vec_req` high. `vec_addr` then holds the winner among the requests that were valid in the `vec_req` cycle, including requests that arrived after the sequence began.
- R6: A sequence can have had a valid request that is gone by the `vec_req` cycle. If no other request is valid in that cycle, `vec_addr` is the vector of the last winner latched during the sequence.
- R7: Suppose no valid request has been seen since reset or since the end of the last sequence. Then a `vec_req` returns 0xFFF6.
- R8: The sequence ends in the cycle where `vec_valid` is high, and the kept vector is discarded then. A later `vec_req` with nothing pending returns 0xFFF6.
- R9: After reset, `vec_valid` is 0 and `vec_addr` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| rst_src | input | 1 | System reset exception request |
| clkmon_src | input | 1 | Clock-monitor reset request |
| wdog_src | input | 1 | Watchdog reset request |
| trap_src | input | 1 | Unimplemented-opcode trap request |
| swi_src | input | 1 | Software interrupt / debug vector request |
| xirq_src | input | 1 | X-maskable external interrupt request |
| irq_src | input | N_MASK | I-maskable interrupt requests |
| i_mask | input | 1 | I mask bit (1 = maskable sources blocked) |
| x_mask | input | 1 | X mask bit (1 = xirq_src blocked) |
| prom_we | input | 1 | Promotion register write enable |
| prom_wdata | input | 8 | Promotion register write data (vector low byte) |
| vec_req | input | 1 | Vector request strobe from the CPU |
| vec_addr | output | 16 | Registered vector address |
| vec_valid | output | 1 | High one cycle after vec_req |

## Verification
The kept vector is the state most likely to go wrong without being seen. If it is never filled, a vanished request comes back as 0xFFF6 in the very `vec_valid` cycle that follows the strobe. If it is not cleared when a sequence ends, the next empty strobe returns a stale maskable vector one sequence later. An error in ranking or promotion shows up only at a `vec_req` where the affected sources compete. The tests therefore build those contests on purpose, and they read the address one cycle after each strobe.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int NFIX = 6;
  localparam logic [15:0] SWI_VEC  = 16'hFFF6;
  localparam logic [15:0] FIX_TOP  = 16'hFFFE;
  localparam logic [15:0] MASK_TOP = 16'hFFF2;

  function automatic logic [15:0] fixed_vec(input int idx);
    return FIX_TOP - 16'(2 * idx);
  endfunction

  function automatic logic [15:0] mask_vec(input int idx);
    return MASK_TOP - 16'(2 * idx);
  endfunction
endpackage

// File: rtl/ivd_promo.sv
module ivd_promo
  import ivd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] prom
);
  localparam logic [15:0] DEF_VEC = mask_vec(0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prom <= DEF_VEC[7:0];
    else if (we) prom <= wdata;
  end
endmodule

// File: rtl/ivd_rank.sv
module ivd_rank
  import ivd_pkg::*;
#(
  parameter int N_MASK = 8
) (
  input  logic [NFIX-1:0]   fix_vld,
  input  logic [N_MASK-1:0] msk_vld,
  input  logic [7:0]        prom,
  output logic              win_vld,
  output logic              win_is_mask,
  output logic [15:0]       win_vec
);
  logic [N_MASK-1:0] prom_hit;

  generate
    for (genvar k = 0; k < N_MASK; k++) begin : g_hit
      localparam logic [15:0] MV = mask_vec(k);
      assign prom_hit[k] = msk_vld[k] && (prom == MV[7:0]);
    end
  endgenerate

  always_comb begin
    win_vld     = 1'b0;
    win_is_mask = 1'b0;
    win_vec     = SWI_VEC;
    for (int k = N_MASK - 1; k >= 0; k--) begin
      if (msk_vld[k]) begin
        win_vld     = 1'b1;
        win_is_mask = 1'b1;
        win_vec     = mask_vec(k);
      end
    end
    for (int k = 0; k < N_MASK; k++) begin
      if (prom_hit[k]) win_vec = mask_vec(k);
    end
    for (int f = NFIX - 1; f >= 0; f--) begin
      if (fix_vld[f]) begin
        win_vld     = 1'b1;
        win_is_mask = 1'b0;
        win_vec     = fixed_vec(f);
      end
    end
  end
endmodule

// File: rtl/ivd_seq.sv
module ivd_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_vld,
  input  logic [15:0] win_vec,
  input  logic        seq_end,
  output logic        seq_on,
  output logic        lv_have,
  output logic [15:0] lv_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_on  <= 1'b0;
      lv_have <= 1'b0;
      lv_vec  <= 16'h0000;
    end else if (seq_end) begin
      seq_on  <= 1'b0;
      lv_have <= 1'b0;
    end else if (win_vld) begin
      seq_on  <= 1'b1;
      lv_have <= 1'b1;
      lv_vec  <= win_vec;
    end
  end
endmodule

// File: rtl/irq_vec_decoder.sv
module irq_vec_decoder
  import ivd_pkg::*;
#(
  parameter int N_MASK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_src,
  input  logic              clkmon_src,
  input  logic              wdog_src,
  input  logic              trap_src,
  input  logic              swi_src,
  input  logic              xirq_src,
  input  logic [N_MASK-1:0] irq_src,
  input  logic              i_mask,
  input  logic              x_mask,
  input  logic              prom_we,
  input  logic [7:0]        prom_wdata,
  input  logic              vec_req,
  output logic [15:0]       vec_addr,
  output logic              vec_valid
);
  logic [NFIX-1:0]   fix_vld;
  logic [N_MASK-1:0] msk_vld;
  logic [7:0]        prom;
  logic              win_vld, win_is_mask;
  logic [15:0]       win_vec;
  logic              seq_on, lv_have;
  logic [15:0]       lv_vec;
  logic              seq_end;
  logic [15:0]       pick_vec;

  assign fix_vld = {xirq_src & ~x_mask, swi_src, trap_src, wdog_src, clkmon_src, rst_src};
  assign msk_vld = irq_src & {N_MASK{~i_mask}};
  assign seq_end = vec_valid;

  ivd_promo u_promo (
    .clk(clk), .rst_n(rst_n), .we(prom_we), .wdata(prom_wdata), .prom(prom)
  );

  ivd_rank #(.N_MASK(N_MASK)) u_rank (
    .fix_vld(fix_vld), .msk_vld(msk_vld), .prom(prom),
    .win_vld(win_vld), .win_is_mask(win_is_mask), .win_vec(win_vec)
  );

  ivd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_vec(win_vec),
    .seq_end(seq_end), .seq_on(seq_on), .lv_have(lv_have), .lv_vec(lv_vec)
  );

  always_comb begin
    if (win_vld)      pick_vec = win_vec;
    else if (lv_have) pick_vec = lv_vec;
    else              pick_vec = SWI_VEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= 16'h0000;
    end else begin
      vec_valid <= vec_req;
      if (vec_req) vec_addr <= pick_vec;
    end
  end
endmodule

// File: rtl/ivd_checker.sv
module ivd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        vec_req,
  input logic        vec_valid,
  input logic [15:0] vec_addr,
  input logic        rst_src,
  input logic        i_mask,
  input logic        win_vld,
  input logic        win_is_mask,
  input logic        lv_have,
  input logic [15:0] lv_vec
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) vec_req |=> vec_valid); // R5
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !vec_req |=> !vec_valid); // R5
  AST_RESET_SRC_WINS: assert property (@(posedge clk) disable iff (!rst_n) (vec_req && rst_src) |=> vec_addr == 16'hFFFE); // R1
  AST_MASKED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n) (win_vld && win_is_mask) |-> !i_mask); // R3
  AST_FALLBACK_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (vec_req && !win_vld && lv_have) |=> vec_addr == $past(lv_vec)); // R6
  AST_EMPTY_GIVES_SWI: assert property (@(posedge clk) disable iff (!rst_n) (vec_req && !win_vld && !lv_have) |=> vec_addr == 16'hFFF6); // R7
  AST_SEQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |=> !lv_have); // R8
endmodule

bind irq_vec_decoder ivd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vec_req(vec_req), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .rst_src(rst_src), .i_mask(i_mask),
  .win_vld(win_vld), .win_is_mask(win_is_mask),
  .lv_have(lv_have), .lv_vec(lv_vec)
);

// File: tb/sim_irq_vec_decoder.sv
`timescale 1ns/1ps
module sim_irq_vec_decoder;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_src = 0, clkmon_src = 0, wdog_src = 0, trap_src = 0, swi_src = 0, xirq_src = 0;
  logic [N-1:0] irq_src = '0;
  logic i_mask = 0, x_mask = 0, prom_we = 0, vec_req = 0;
  logic [7:0] prom_wdata = 8'h00;
  logic [15:0] vec_addr;
  logic vec_valid;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_vec_decoder #(.N_MASK(N)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_src(rst_src), .clkmon_src(clkmon_src),
    .wdog_src(wdog_src), .trap_src(trap_src), .swi_src(swi_src), .xirq_src(xirq_src),
    .irq_src(irq_src), .i_mask(i_mask), .x_mask(x_mask), .prom_we(prom_we),
    .prom_wdata(prom_wdata), .vec_req(vec_req), .vec_addr(vec_addr), .vec_valid(vec_valid)
  );

  function automatic logic [15:0] mvec(input int k);
    return 16'hFFF2 - 16'(k * 2);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_src();
    rst_src = 0; clkmon_src = 0; wdog_src = 0; trap_src = 0; swi_src = 0;
    xirq_src = 0; irq_src = '0; i_mask = 0; x_mask = 0;
  endtask

  // strobe vec_req, check the address and the one-cycle valid pulse
  task automatic serve(input string tag, input logic [15:0] exp);
    @(negedge clk); vec_req = 1;
    @(negedge clk); vec_req = 0;
    check({tag, " valid"}, {15'd0, vec_valid}, 16'd1);
    check(tag, vec_addr, exp);
    @(negedge clk);
    check({tag, " R5 pulse end"}, {15'd0, vec_valid}, 16'd0);
  endtask

  task automatic flush();
    @(negedge clk); clear_src();
    @(negedge clk); vec_req = 1;
    @(negedge clk); vec_req = 0;
    @(negedge clk);
  endtask

  task automatic set_prom(input logic [7:0] v);
    @(negedge clk); prom_we = 1; prom_wdata = v;
    @(negedge clk); prom_we = 0;
  endtask

  task automatic t_reset();
    check("R9 valid at reset", {15'd0, vec_valid}, 16'd0);
    check("R9 addr at reset", vec_addr, 16'h0000);
  endtask

  task automatic t_empty();
    serve("R7 nothing pending", 16'hFFF6);
  endtask

  task automatic t_fixed();
    for (int f = 0; f < 6; f++) begin
      @(negedge clk); clear_src();
      case (f)
        0: rst_src = 1; 1: clkmon_src = 1; 2: wdog_src = 1;
        3: trap_src = 1; 4: swi_src = 1; default: xirq_src = 1;
      endcase
      irq_src = '1;
      serve($sformatf("R1 fixed %0d", f), 16'hFFFE - 16'(2 * f));
    end
    @(negedge clk);
    clkmon_src = 1; wdog_src = 1; trap_src = 1; swi_src = 1; xirq_src = 1; rst_src = 1;
    serve("R1 all fixed", 16'hFFFE);
    @(negedge clk); rst_src = 0; clkmon_src = 0;
    serve("R1 wdog over lower", 16'hFFFA);
    flush();
  endtask

  task automatic t_mask_src();
    for (int k = 0; k < N; k++) begin
      @(negedge clk); clear_src(); irq_src[k] = 1;
      serve($sformatf("R2 irq %0d", k), mvec(k));
    end
    @(negedge clk); clear_src(); irq_src = 8'b1010_1000;
    serve("R2 lowest index wins", mvec(3));
    flush();
  endtask

  task automatic t_masks();
    @(negedge clk); clear_src(); i_mask = 1; irq_src = '1;
    serve("R3 I mask blocks", 16'hFFF6);
    @(negedge clk); clear_src(); x_mask = 1; xirq_src = 1; irq_src[6] = 1;
    serve("R3 X mask blocks xirq", mvec(6));
    @(negedge clk); clear_src(); x_mask = 1; i_mask = 1; trap_src = 1;
    serve("R3 trap unmasked", 16'hFFF8);
    flush();
  endtask

  task automatic t_promo();
    logic [15:0] v5;
    v5 = mvec(5);
    set_prom(v5[7:0]);
    @(negedge clk); clear_src(); irq_src[1] = 1; irq_src[5] = 1;
    serve("R4 promoted wins", v5);
    @(negedge clk); xirq_src = 1;
    serve("R4 xirq over promoted", 16'hFFF4);
    @(negedge clk); clear_src(); irq_src[1] = 1;
    serve("R4 promoted idle", mvec(1));
    set_prom(8'h11);
    @(negedge clk); clear_src(); irq_src[2] = 1; irq_src[7] = 1;
    serve("R4 no match default", mvec(2));
    set_prom(8'hF2);
    flush();
  endtask

  task automatic t_late();
    @(negedge clk); clear_src(); irq_src[3] = 1;
    repeat (3) @(negedge clk);
    trap_src = 1; vec_req = 1;
    @(negedge clk); vec_req = 0;
    check("R5 late trap wins", vec_addr, 16'hFFF8);
    flush();
  endtask

  task automatic t_fallback();
    @(negedge clk); clear_src(); irq_src[4] = 1;
    repeat (2) @(negedge clk);
    irq_src = '0;
    serve("R6 vanished irq", mvec(4));
    serve("R8 after sequence end", 16'hFFF6);
    @(negedge clk); irq_src[6] = 1;
    @(negedge clk); irq_src[2] = 1;
    @(negedge clk); irq_src = '0;
    serve("R6 last winner kept", mvec(2));
    flush();
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5; t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_empty();
    t_fixed();
    t_mask_src();
    t_masks();
    t_promo();
    t_late();
    t_fallback();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule